// File: doc/BRIEF.md
# Torus Minimal Route Selector

This block chooses the outgoing link for a packet header at one node of a three-dimensional wraparound mesh. It is given the node's own position, the packet's target position, and the ring length currently configured in each dimension. For each dimension it works out the shorter way around the ring, which may be the plus or the minus side. A direction counts as productive when a hop along it shortens the remaining path. The block then selects one productive direction, or it reports that the packet has arrived.

Two policies can be chosen at run time. The fixed policy resolves the dimensions strictly in the order x, y, z, and it ignores traffic. The traffic-aware policy compares the credit counts of the productive links and takes the link with the most free credits. The decision is registered. It appears one clock after the header is presented and holds until the next header.

Top module: `torus_route_sel`

## Requirements
- R1: While reset is asserted, and after reset until the first header arrives, `route_valid`, `route_dir` and `route_local` are all zero.
- R2: `route_valid` is high in exactly the cycle after a cycle with `hdr_valid` high. The decision for that header is on the outputs in that same cycle.
- R3: When the destination equals the node position in all three dimensions, `route_local` is 1 and `route_dir` is zero.
- R4: Otherwise `route_local` is 0 and `route_dir` has exactly one bit set. The bit mapping is: bit 0 = +x, bit 1 = -x, bit 2 = +y, bit 3 = -y, bit 4 = +z, bit 5 = -z.
- R5: Per dimension, the forward distance is f = (dest - here) mod ring. The minus link of that dimension is productive when 2f > ring. The plus link is productive when 0 < 2f <= ring. A dimension with f = 0 offers no link. The chosen link is always a productive one.
- R6: When 2f equals the ring size exactly, the plus link of that dimension is the productive one.
- R7: With `adaptive_mode` = 0, the link is taken from the first dimension, in x, y, z order, whose f is nonzero. `link_credit` has no effect on the choice.
- R8: With `adaptive_mode` = 1, the productive link whose credit field is largest is chosen. On equal credits, the lower dimension wins (x before y before z). The credit field for bit d of `route_dir` is `link_credit[d*CW +: CW]`.
- R9: The ring sizes are runtime inputs. Any ring size from 1 up to 2^width is honoured, including the largest configuration of 32 x 32 x 64, provided each coordinate is below its ring size.
- R10: In cycles after a cycle with `hdr_valid` low, `route_dir` and `route_local` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | A header is presented this cycle |
| adaptive_mode | input | 1 | 1 = traffic-aware policy, 0 = fixed dimension order |
| here_x | input | XW | Node x coordinate |
| here_y | input | YW | Node y coordinate |
| here_z | input | ZW | Node z coordinate |
| dest_x | input | XW | Target x coordinate |
| dest_y | input | YW | Target y coordinate |
| dest_z | input | ZW | Target z coordinate |
| ring_x | input | XW+1 | Ring length in x |
| ring_y | input | YW+1 | Ring length in y |
| ring_z | input | ZW+1 | Ring length in z |
| link_credit | input | 6*CW | Free-credit count per output link, field d for direction bit d |
| route_valid | output | 1 | Decision valid this cycle |
| route_dir | output | 6 | One-hot chosen link |
| route_local | output | 1 | Packet has reached this node |

## Verification
The first sweep takes a small torus of 4 x 3 x 5 and visits every pair of node and target position under both policies. This covers wraparound in even and odd rings, the exact half-ring tie, and every combination of zero and nonzero offsets. The credits change with each header, so equal and distinct credit values both reach the traffic-aware tie-break. A second set of spread-out headers on 8 x 8 x 8 and 32 x 32 x 64 rings shows that the ring-size inputs, not the field widths, set the wrap point. Directed headers then show three more things: the tie at half the ring, that credits have no effect under the fixed policy, and the x-first priority on equal credits. After every header the bench changes all inputs with no header present, which separates a registered decision that holds from one that follows the inputs.

// File: rtl/trs_pkg.sv
package trs_pkg;
   localparam int NDIM = 3;
   localparam int NDIR = 2 * NDIM;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/trs_ring_offset.sv
module trs_ring_offset #(
   parameter int W = 6
) (
   input  logic [W-1:0] here,
   input  logic [W-1:0] there,
   input  logic [W:0]   ring,
   output logic         need,
   output logic         go_minus
);
   logic [W+1:0] sum;
   logic [W+1:0] fwd;
   logic [W+2:0] twice;

   always_comb begin
      sum   = {2'b00, there} + {1'b0, ring} - {2'b00, here};
      fwd   = (sum >= {1'b0, ring}) ? (sum - {1'b0, ring}) : sum;
      twice = {fwd, 1'b0};
      need     = (fwd != '0);
      go_minus = need && (twice > {2'b00, ring});
   end
endmodule

// File: rtl/trs_dir_pick.sv
module trs_dir_pick
   import trs_pkg::*;
#(
   parameter int CW          = 4,
   parameter bit ADAPTIVE_EN = 1'b1
) (
   input  logic [NDIM-1:0]      need,
   input  logic [NDIM-1:0]      minus,
   input  logic                 adaptive,
   input  logic [NDIR*CW-1:0]   cred,
   output logic [NDIR-1:0]      sel
);
   logic [NDIR-1:0] det_sel;
   logic [NDIR-1:0] ada_sel;

   always_comb begin
      logic found;
      det_sel = '0;
      found   = 1'b0;
      for (int i = 0; i < NDIM; i++) begin
         if (need[i] && !found) begin
            det_sel[2*i + int'(minus[i])] = 1'b1;
            found = 1'b1;
         end
      end
   end

   generate
      if (ADAPTIVE_EN) begin : g_adaptive
         always_comb begin
            logic          have;
            logic [CW-1:0] best_c;
            logic [CW-1:0] c;
            logic [2:0]    best_i;
            logic [2:0]    idx;
            ada_sel = '0;
            have    = 1'b0;
            best_c  = '0;
            best_i  = '0;
            for (int i = 0; i < NDIM; i++) begin
               idx = 3'(2*i) + {2'b00, minus[i]};
               c   = cred[idx*CW +: CW];
               if (need[i] && (!have || c > best_c)) begin
                  have   = 1'b1;
                  best_c = c;
                  best_i = idx;
               end
            end
            if (have) ada_sel[best_i] = 1'b1;
         end
      end else begin : g_fixed_only
         logic unused_cred;
         assign unused_cred = ^cred;
         assign ada_sel     = det_sel;
      end
   endgenerate

   assign sel = adaptive ? ada_sel : det_sel;
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
   import trs_pkg::*;
#(
   parameter int XW          = 5,
   parameter int YW          = 5,
   parameter int ZW          = 6,
   parameter int CW          = 4,
   parameter bit ADAPTIVE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hdr_valid,
   input  logic               adaptive_mode,
   input  logic [XW-1:0]      here_x,
   input  logic [YW-1:0]      here_y,
   input  logic [ZW-1:0]      here_z,
   input  logic [XW-1:0]      dest_x,
   input  logic [YW-1:0]      dest_y,
   input  logic [ZW-1:0]      dest_z,
   input  logic [XW:0]        ring_x,
   input  logic [YW:0]        ring_y,
   input  logic [ZW:0]        ring_z,
   input  logic [NDIR*CW-1:0] link_credit,
   output logic               route_valid,
   output logic [NDIR-1:0]    route_dir,
   output logic               route_local
);
   localparam int MW = max3(XW, YW, ZW);

   if (XW < 1 || YW < 1 || ZW < 1 || MW > 16) begin : g_bad_width
      $error("torus_route_sel: coordinate widths must lie in 1..16");
   end
   if (CW < 1 || CW > 16) begin : g_bad_credit
      $error("torus_route_sel: credit width must lie in 1..16");
   end

   logic [MW-1:0]   hv [NDIM];
   logic [MW-1:0]   dv [NDIM];
   logic [MW:0]     rv [NDIM];
   logic [NDIM-1:0] need;
   logic [NDIM-1:0] minus;
   logic [NDIR-1:0] sel;

   assign hv[0] = MW'(here_x);
   assign hv[1] = MW'(here_y);
   assign hv[2] = MW'(here_z);
   assign dv[0] = MW'(dest_x);
   assign dv[1] = MW'(dest_y);
   assign dv[2] = MW'(dest_z);
   assign rv[0] = (MW+1)'(ring_x);
   assign rv[1] = (MW+1)'(ring_y);
   assign rv[2] = (MW+1)'(ring_z);

   for (genvar g = 0; g < NDIM; g++) begin : g_dim
      trs_ring_offset #(.W(MW)) i_off (
         .here     (hv[g]),
         .there    (dv[g]),
         .ring     (rv[g]),
         .need     (need[g]),
         .go_minus (minus[g])
      );
   end

   trs_dir_pick #(.CW(CW), .ADAPTIVE_EN(ADAPTIVE_EN)) i_pick (
      .need     (need),
      .minus    (minus),
      .adaptive (adaptive_mode),
      .cred     (link_credit),
      .sel      (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_valid <= 1'b0;
         route_dir   <= '0;
         route_local <= 1'b0;
      end else begin
         route_valid <= hdr_valid;
         if (hdr_valid) begin
            route_dir   <= sel;
            route_local <= ~|need;
         end
      end
   end
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
   parameter int XW = 5,
   parameter int YW = 5,
   parameter int ZW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hdr_valid,
   input logic          adaptive_mode,
   input logic [XW-1:0] here_x,
   input logic [YW-1:0] here_y,
   input logic [ZW-1:0] here_z,
   input logic [XW-1:0] dest_x,
   input logic [YW-1:0] dest_y,
   input logic [ZW-1:0] dest_z,
   input logic          route_valid,
   input logic [5:0]    route_dir,
   input logic          route_local
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> route_valid); // R2
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> !route_valid); // R2
   AST_LOCAL_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && route_local) |-> (route_dir == 6'b0)); // R3
   AST_ONE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && !route_local) |-> ($countones(route_dir) == 1)); // R4
   AST_X_PRODUCTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && (route_dir[1:0] != 2'b0)) |-> ($past(dest_x) != $past(here_x))); // R5
   AST_Y_PRODUCTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && (route_dir[3:2] != 2'b0)) |-> ($past(dest_y) != $past(here_y))); // R5
   AST_Z_PRODUCTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && (route_dir[5:4] != 2'b0)) |-> ($past(dest_z) != $past(here_z))); // R5
   AST_DIM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && !$past(adaptive_mode) && ($past(dest_x) != $past(here_x)))
         |-> (route_dir[1:0] != 2'b0)); // R7
   AST_HOLD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> ($stable(route_dir) && $stable(route_local))); // R10
   AST_ZERO_OR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(route_dir)); // R4
endmodule

bind torus_route_sel trs_checker #(.XW(XW), .YW(YW), .ZW(ZW)) i_trs_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .hdr_valid     (hdr_valid),
   .adaptive_mode (adaptive_mode),
   .here_x        (here_x),
   .here_y        (here_y),
   .here_z        (here_z),
   .dest_x        (dest_x),
   .dest_y        (dest_y),
   .dest_z        (dest_z),
   .route_valid   (route_valid),
   .route_dir     (route_dir),
   .route_local   (route_local)
);

// File: tb/test_torus_route_sel.sv
module test_torus_route_sel;
   localparam int CLK_PERIOD = 10;
   localparam int XW = 5;
   localparam int YW = 5;
   localparam int ZW = 6;
   localparam int CW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            hdr_valid = 1'b0;
   logic            adaptive_mode = 1'b0;
   logic [XW-1:0]   here_x = '0;
   logic [YW-1:0]   here_y = '0;
   logic [ZW-1:0]   here_z = '0;
   logic [XW-1:0]   dest_x = '0;
   logic [YW-1:0]   dest_y = '0;
   logic [ZW-1:0]   dest_z = '0;
   logic [XW:0]     ring_x = 6'd4;
   logic [YW:0]     ring_y = 6'd3;
   logic [ZW:0]     ring_z = 7'd5;
   logic [6*CW-1:0] link_credit = '0;
   logic            route_valid;
   logic [5:0]      route_dir;
   logic            route_local;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   torus_route_sel #(.XW(XW), .YW(YW), .ZW(ZW), .CW(CW), .ADAPTIVE_EN(1'b1)) i_torus_route_sel (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .adaptive_mode(adaptive_mode),
      .here_x(here_x), .here_y(here_y), .here_z(here_z),
      .dest_x(dest_x), .dest_y(dest_y), .dest_z(dest_z),
      .ring_x(ring_x), .ring_y(ring_y), .ring_z(ring_z),
      .link_credit(link_credit), .route_valid(route_valid),
      .route_dir(route_dir), .route_local(route_local)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int fwd_dist(input int h, input int d, input int r);
      return (((d - h) % r) + r) % r;
   endfunction

   // returns {local, dir[5:0]} computed from the requirement text
   function automatic logic [6:0] expect_route(input int h[3], input int d[3], input int r[3],
                                               input bit ad, input logic [6*CW-1:0] cr);
      int best;
      int bc;
      int first;
      logic [6:0] res;
      best  = -1;
      bc    = -1;
      first = -1;
      for (int i = 0; i < 3; i++) begin
         int f;
         int link;
         int c;
         f = fwd_dist(h[i], d[i], r[i]);
         if (f != 0) begin
            link = (2*f > r[i]) ? 2*i + 1 : 2*i;
            c    = int'(cr[link*CW +: CW]);
            if (first < 0) first = link;
            if (best < 0 || c > bc) begin
               best = link;
               bc   = c;
            end
         end
      end
      res = '0;
      if (first < 0) res[6] = 1'b1;
      else res[ad ? best : first] = 1'b1;
      return res;
   endfunction

   function automatic logic [6*CW-1:0] mk_cred(input int k);
      logic [6*CW-1:0] v;
      for (int d = 0; d < 6; d++) v[d*CW +: CW] = CW'((k*3 + d*d*5 + k/7) % (1 << CW));
      return v;
   endfunction

   // entered just after a falling edge; leaves just after a falling edge
   task automatic apply(input int hx, input int hy, input int hz,
                        input int dx, input int dy, input int dz,
                        input int rx, input int ry, input int rz,
                        input bit ad, input logic [6*CW-1:0] cr, input string tag);
      int h[3];
      int d[3];
      int r[3];
      logic [6:0] e;
      logic [6:0] held;
      h = '{hx, hy, hz};
      d = '{dx, dy, dz};
      r = '{rx, ry, rz};
      e = expect_route(h, d, r, ad, cr);
      here_x = XW'(hx); here_y = YW'(hy); here_z = ZW'(hz);
      dest_x = XW'(dx); dest_y = YW'(dy); dest_z = ZW'(dz);
      ring_x = (XW+1)'(rx); ring_y = (YW+1)'(ry); ring_z = (ZW+1)'(rz);
      adaptive_mode = ad;
      link_credit   = cr;
      hdr_valid     = 1'b1;
      @(negedge clk);
      chk(32'(route_valid), 32'd1, "R2 valid one cycle after header");
      chk(32'({route_local, route_dir}), 32'(e), e[6] ? "R3 local delivery" : tag);
      held = {route_local, route_dir};
      hdr_valid     = 1'b0;
      dest_x        = ~dest_x;
      dest_z        = ~dest_z;
      adaptive_mode = ~ad;
      link_credit   = ~cr;
      @(negedge clk);
      chk(32'(route_valid), 32'd0, "R2 valid drops without header");
      chk(32'({route_local, route_dir}), 32'(held), "R10 decision held");
   endtask

   initial begin
      int k;
      k = 0;
      #1;
      chk(32'({route_valid, route_local, route_dir}), 32'd0, "R1 in reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(32'({route_valid, route_local, route_dir}), 32'd0, "R1 after reset");

      // full sweep over a 4 x 3 x 5 torus, both policies
      for (int mode = 0; mode < 2; mode++)
         for (int a = 0; a < 60; a++)
            for (int b = 0; b < 60; b++) begin
               apply(a % 4, (a / 4) % 3, a / 12, b % 4, (b / 4) % 3, b / 12, 4, 3, 5,
                     mode[0], mk_cred(k), mode != 0 ? "R4 R5 R8 traffic-aware" : "R4 R5 R7 fixed order");
               k++;
            end

      // spread headers on partition sizes up to the largest ring
      for (int n = 0; n < 300; n++) begin
         apply((n*5) % 8, (n*3) % 8, (n*7) % 8, (n*11) % 8, (n*13) % 8, n % 8, 8, 8, 8,
               n[0], mk_cred(n), "R9 ring 8");
         apply((n*7) % 32, (n*9) % 32, (n*17) % 64, (n*13) % 32, (n*5) % 32, (n*29) % 64,
               32, 32, 64, n[1], mk_cred(n + 5), "R9 ring 32x32x64");
      end

      // half-ring tie: plus side
      apply(3, 0, 0, 19, 0, 0, 32, 32, 64, 1'b0, '0, "R6 tie x ring 32");
      chk(32'(route_dir), 32'h01, "R6 tie chooses +x");
      apply(0, 0, 0, 0, 0, 32, 32, 32, 64, 1'b1, '0, "R6 tie z ring 64");
      chk(32'(route_dir), 32'h10, "R6 tie chooses +z");
      apply(3, 0, 0, 20, 0, 0, 32, 32, 64, 1'b0, '0, "R5 just past half");
      chk(32'(route_dir), 32'h02, "R5 past half chooses -x");
      apply(30, 0, 0, 1, 0, 0, 32, 32, 64, 1'b0, '0, "R9 wrap forward");
      chk(32'(route_dir), 32'h01, "R9 wrap through ring end chooses +x");

      // fixed order ignores credits
      apply(1, 1, 1, 2, 2, 2, 8, 8, 8, 1'b0, {CW'(15), CW'(15), CW'(15), CW'(15), CW'(0), CW'(0)}, "R7 credits 1");
      chk(32'(route_dir), 32'h01, "R7 credits ignored, x first");
      // traffic-aware: z wins on credit, then equal credits fall back to x
      apply(1, 1, 1, 2, 2, 2, 8, 8, 8, 1'b1, {CW'(0), CW'(9), CW'(0), CW'(3), CW'(0), CW'(3)}, "R8 credit max");
      chk(32'(route_dir), 32'h10, "R8 largest credit picks +z");
      apply(1, 1, 1, 2, 2, 2, 8, 8, 8, 1'b1, {6{CW'(5)}}, "R8 credit tie");
      chk(32'(route_dir), 32'h01, "R8 equal credits prefer x");
      apply(1, 1, 1, 1, 2, 2, 8, 8, 8, 1'b1, {6{CW'(5)}}, "R8 credit tie y");
      chk(32'(route_dir), 32'h04, "R8 equal credits prefer y over z");
      apply(5, 6, 7, 5, 6, 7, 8, 8, 8, 1'b1, '1, "R3 arrived");
      chk(32'({route_local, route_dir}), 32'h40, "R3 local, no link");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule